// File: doc/BRIEF.md
# Nine-bit three-wire serial configuration target

This block is the host-facing register slave of a display bridge. A host talks to it over a three-wire serial link: a serial clock, an active-low select, and one data line that the block drives only while it answers a read. Every word on the link is nine bits long. The leading bit says whether the word is a command or data. A command carries an 8-bit register address and a data word carries one byte. The block keeps the bank of 16-bit configuration registers at addresses 0xB0 to 0xFF. The core reads that bank through a plain parallel port with one cycle of latency.

The host writes a register with three words: the address, then the low byte, then the high byte. A read uses a handshake. The host first writes the arming key to the arming register, then sends the target address as a command. It then sends one further nine-bit word and clocks sixteen more bits, which the block shifts out most significant bit first. A command to the payload port address turns the following data bytes into a packet stream. That stream goes through a small byte FIFO, and the core drains it over a valid/ready interface. The core may hold ready low as long as it likes: the byte at the head and its valid stay put. The serial side cannot be stalled, so a byte that arrives while the FIFO is full is lost.

All serial inputs are synchronised into the system clock. The serial clock must run at a quarter of the system clock rate or slower.

Top module: `spi9_cfg_slave`

## Requirements
- R1: A word is nine bits sampled on rising serial clock edges while select is low. The first bit is the type (0 = command, 1 = data), and the eight bits after it are the address or data byte, most significant bit first.
- R2: A data word after a command latches the low byte. The next data word supplies bits 15..8 and commits the 16-bit value to the addressed register. The core port shows it one cycle after the address is presented.
- R3: A data word that follows no command since reset is ignored. A third or later data word after an ordinary register command is ignored.
- R4: Address 0xB0 always reads the DEV_ID parameter and writes to it are ignored. Addresses below 0xB0 read as zero and writes to them are ignored.
- R5: Writing 0x00FA to 0xD4 arms a read, and the next command word names the register to read. The word after that is consumed. The next 16 serial clocks then carry that register's value MSB first: the first bit is valid before the first rising edge and each following bit changes on a falling edge. The data-enable output is high only during those 16 bits.
- R6: A command to 0xBF opens the payload port. Each following data word is pushed as one byte until the number of bytes equals register 0xBC, and later data bytes are ignored. A new 0xBF command restarts the count, and any other command closes the port.
- R7: The packet output raises valid while the FIFO holds bytes. The byte and valid are held while ready is low, and bytes come out in arrival order.
- R8: A payload byte that arrives while the FIFO is full is dropped but still counts toward the 0xBC limit. The FIFO never holds more than its depth.
- R9: Writing 0x0100 to 0xC0 clears every register to zero. Any other value written to 0xC0 is stored like an ordinary register.
- R10: Raising select in the middle of a word discards the partial bits, and the next word starts at the next select assertion. The command, payload and read-handshake state carry over across select pulses.
- R11: After reset all registers read zero, packet valid is low and the data-enable output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sck | input | 1 | Serial clock from the host |
| spi_cs_n | input | 1 | Active-low select |
| spi_sdi | input | 1 | Serial data from the host |
| spi_sdo | output | 1 | Serial read data to the host |
| spi_sdo_en | output | 1 | Enable for the shared data line during read bits |
| core_addr | input | 8 | Register address for the core read port |
| core_rdata | output | 16 | Register value, one cycle after core_addr |
| pkt_valid | output | 1 | Payload byte available |
| pkt_ready | input | 1 | Core accepts the payload byte |
| pkt_data | output | 8 | Payload byte |

## Verification
Register values with alternating bits, all ones and a single low bit are written and read back both over the serial handshake and through the core port. This separates a byte swap, a shift-order error and an off-by-one in the output shifter. Stray data words, third data bytes, writes to the identity and unmapped addresses, and words cut short by select show whether each ignore rule holds without corrupting the next correct write. Payload bursts shorter than, equal to and longer than the count register are sent, plus a burst beyond the FIFO depth, and drained with a stalling ready. These tell the count limit apart from the overflow drop and test that bytes are held under back-pressure.

// File: rtl/spi9_pkg.sv
package spi9_pkg;
  localparam int DATA_W = 16;
  localparam int BYTE_W = 8;
  localparam int WORD_BITS = 9;

  localparam logic [7:0] A_BASE     = 8'hB0;
  localparam logic [7:0] A_IDENT    = 8'hB0;
  localparam logic [7:0] A_PKT_LEN  = 8'hBC;
  localparam logic [7:0] A_PKT_PORT = 8'hBF;
  localparam logic [7:0] A_SWRST    = 8'hC0;
  localparam logic [7:0] A_RD_ARM   = 8'hD4;

  localparam logic [15:0] RD_ARM_KEY = 16'h00FA;
  localparam logic [15:0] SWRST_KEY  = 16'h0100;

  typedef struct packed {
    logic             is_data;
    logic [BYTE_W-1:0] val;
  } spi_word_t;
endpackage

// File: rtl/spi9_sync.sv
module spi9_sync #(
  parameter int N = 3,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    logic s1, s2;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1 <= RST_VAL[i];
        s2 <= RST_VAL[i];
      end else begin
        s1 <= d[i];
        s2 <= s1;
      end
    end
    assign q[i] = s2;
  end
endmodule

// File: rtl/spi9_frame.sv
module spi9_frame
  import spi9_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck_s,
  input  logic              cs_n_s,
  input  logic              sdi_s,
  input  logic              rd_load,
  input  logic [DATA_W-1:0] rd_value,
  output logic              word_stb,
  output spi_word_t         word_out,
  output logic              sdo,
  output logic              sdo_en
);
  localparam int CNT_W = $clog2(WORD_BITS);
  localparam int OCNT_W = $clog2(DATA_W) + 1;

  logic sck_d, rise, fall;
  logic [CNT_W-1:0] bit_cnt;
  logic [WORD_BITS-1:0] in_sh;
  logic shifting;
  logic [DATA_W-1:0] out_sh;
  logic [OCNT_W-1:0] out_cnt;

  assign rise = sck_s & ~sck_d;
  assign fall = ~sck_s & sck_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_d    <= 1'b0;
      bit_cnt  <= '0;
      in_sh    <= '0;
      word_stb <= 1'b0;
      shifting <= 1'b0;
      out_sh   <= '0;
      out_cnt  <= '0;
    end else begin
      sck_d    <= sck_s;
      word_stb <= 1'b0;
      if (cs_n_s) begin
        bit_cnt  <= '0;
        shifting <= 1'b0;
        out_cnt  <= '0;
      end else if (rd_load) begin
        shifting <= 1'b1;
        out_sh   <= rd_value;
        out_cnt  <= '0;
      end else if (shifting) begin
        if (rise) begin
          out_cnt <= out_cnt + 1'b1;
          if (out_cnt == OCNT_W'(DATA_W - 1)) shifting <= 1'b0;
        end
        if (fall && out_cnt != '0) out_sh <= {out_sh[DATA_W-2:0], 1'b0};
      end else if (rise) begin
        in_sh <= {in_sh[WORD_BITS-2:0], sdi_s};
        if (bit_cnt == CNT_W'(WORD_BITS - 1)) begin
          bit_cnt  <= '0;
          word_stb <= 1'b1;
        end else begin
          bit_cnt <= bit_cnt + 1'b1;
        end
      end
    end
  end

  assign word_out = spi_word_t'(in_sh);
  assign sdo      = out_sh[DATA_W-1];
  assign sdo_en   = shifting;

  a_r1_bit_count_range: assert property (@(posedge clk) disable iff (!rst_n)
    bit_cnt <= CNT_W'(WORD_BITS - 1));
  a_r10_select_abort: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_s |=> (bit_cnt == '0) && !sdo_en);
  a_r5_read_length: assert property (@(posedge clk) disable iff (!rst_n)
    out_cnt <= OCNT_W'(DATA_W));
  a_r5_enable_needs_select: assert property (@(posedge clk) disable iff (!rst_n)
    sdo_en |-> !$past(cs_n_s) || $past(rd_load) || $past(sdo_en));
endmodule

// File: rtl/spi9_regbank.sv
module spi9_regbank
  import spi9_pkg::*;
#(
  parameter logic [DATA_W-1:0] DEV_ID = 16'h5A17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              word_stb,
  input  spi_word_t         word_in,
  input  logic [7:0]        core_addr,
  output logic [DATA_W-1:0] core_rdata,
  output logic              rd_load,
  output logic [DATA_W-1:0] rd_value,
  output logic              push,
  output logic [BYTE_W-1:0] push_data
);
  localparam int NREG  = 256 - int'(A_BASE);
  localparam int IDX_W = $clog2(NREG);

  logic [DATA_W-1:0] regs [NREG];

  logic              have_cmd, armed, rd_wait, pay_open;
  logic [7:0]        cur_addr, rd_addr;
  logic [1:0]        byte_idx;
  logic [BYTE_W-1:0] low_byte;
  logic [DATA_W-1:0] pay_cnt, pay_limit, wr_data;
  logic              wr_ok, soft_rst;

  function automatic logic [IDX_W-1:0] slot(input logic [7:0] a);
    logic [7:0] off;
    off = a - A_BASE;
    return off[IDX_W-1:0];
  endfunction

  function automatic logic [DATA_W-1:0] fetch(input logic [7:0] a);
    if (a == A_IDENT) return DEV_ID;
    if (a < A_BASE) return '0;
    return regs[slot(a)];
  endfunction

  assign wr_data   = {word_in.val, low_byte};
  assign wr_ok     = word_stb && !rd_wait && word_in.is_data && !pay_open && have_cmd
                     && byte_idx == 2'd1 && cur_addr >= A_BASE && cur_addr != A_IDENT;
  assign soft_rst  = wr_ok && cur_addr == A_SWRST && wr_data == SWRST_KEY;
  assign pay_limit = regs[slot(A_PKT_LEN)];
  assign push      = word_stb && !rd_wait && word_in.is_data && pay_open && pay_cnt < pay_limit;
  assign push_data = word_in.val;

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    logic [DATA_W-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else if (soft_rst) q <= '0;
      else if (wr_ok && slot(cur_addr) == IDX_W'(i)) q <= wr_data;
    end
    assign regs[i] = q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      have_cmd   <= 1'b0;
      armed      <= 1'b0;
      rd_wait    <= 1'b0;
      pay_open   <= 1'b0;
      cur_addr   <= '0;
      rd_addr    <= '0;
      byte_idx   <= '0;
      low_byte   <= '0;
      pay_cnt    <= '0;
      rd_load    <= 1'b0;
      rd_value   <= '0;
      core_rdata <= '0;
    end else begin
      core_rdata <= fetch(core_addr);
      rd_load    <= 1'b0;
      if (word_stb) begin
        if (rd_wait) begin
          rd_wait  <= 1'b0;
          rd_load  <= 1'b1;
          rd_value <= fetch(rd_addr);
        end else if (!word_in.is_data) begin
          if (armed) begin
            armed    <= 1'b0;
            rd_wait  <= 1'b1;
            rd_addr  <= word_in.val;
            have_cmd <= 1'b0;
            pay_open <= 1'b0;
          end else if (word_in.val == A_PKT_PORT) begin
            pay_open <= 1'b1;
            pay_cnt  <= '0;
            have_cmd <= 1'b0;
          end else begin
            have_cmd <= 1'b1;
            cur_addr <= word_in.val;
            byte_idx <= '0;
            pay_open <= 1'b0;
          end
        end else if (pay_open) begin
          if (pay_cnt < pay_limit) pay_cnt <= pay_cnt + 1'b1;
        end else if (have_cmd) begin
          if (byte_idx == 2'd0) low_byte <= word_in.val;
          if (byte_idx != 2'd2) byte_idx <= byte_idx + 1'b1;
          if (wr_ok && cur_addr == A_RD_ARM && wr_data == RD_ARM_KEY) armed <= 1'b1;
        end
      end
    end
  end

  a_r4_ident_constant: assert property (@(posedge clk) disable iff (!rst_n)
    core_addr == A_IDENT |=> core_rdata == DEV_ID);
  a_r9_soft_reset_clears: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> pay_limit == '0 && regs[slot(A_SWRST)] == '0);
  a_r6_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    pay_open |-> pay_cnt <= pay_limit);
  a_r3_byte_index_saturates: assert property (@(posedge clk) disable iff (!rst_n)
    byte_idx <= 2'd2);
  a_r5_single_load: assert property (@(posedge clk) disable iff (!rst_n)
    rd_load |=> !rd_load && !rd_wait);
endmodule

// File: rtl/spi9_fifo.sv
module spi9_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output logic         rd_valid,
  input  logic         rd_ready,
  output logic [W-1:0] rd_data
);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0] mem [DEPTH];
  logic [AW:0]  wp, rp, count;
  logic         full;

  assign count    = wp - rp;
  assign full     = count == (AW + 1)'(DEPTH);
  assign rd_valid = wp != rp;
  assign rd_data  = mem[rp[AW-1:0]];

  always_ff @(posedge clk) begin
    if (wr_en && !full) mem[wp[AW-1:0]] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0;
      rp <= '0;
    end else begin
      if (wr_en && !full) wp <= wp + 1'b1;
      if (rd_valid && rd_ready) rp <= rp + 1'b1;
    end
  end

  a_r7_hold_under_stall: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !rd_ready |=> rd_valid && $stable(rd_data));
  a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    count <= (AW + 1)'(DEPTH));
  a_r8_full_drop: assert property (@(posedge clk) disable iff (!rst_n)
    full && wr_en && !rd_ready |=> $stable(wp));
endmodule

// File: rtl/spi9_cfg_slave.sv
module spi9_cfg_slave
  import spi9_pkg::*;
#(
  parameter logic [15:0] DEV_ID     = 16'h5A17,
  parameter int          FIFO_DEPTH = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        spi_sck,
  input  logic        spi_cs_n,
  input  logic        spi_sdi,
  output logic        spi_sdo,
  output logic        spi_sdo_en,
  input  logic [7:0]  core_addr,
  output logic [15:0] core_rdata,
  output logic        pkt_valid,
  input  logic        pkt_ready,
  output logic [7:0]  pkt_data
);
  logic [2:0]        raw_in, synced;
  logic              word_stb, rd_load, push;
  spi_word_t         word_v;
  logic [DATA_W-1:0] rd_value;
  logic [BYTE_W-1:0] push_data;

  assign raw_in = {spi_sck, spi_cs_n, spi_sdi};

  spi9_sync #(.N(3), .RST_VAL(3'b010)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw_in), .q(synced)
  );

  spi9_frame u_frame (
    .clk(clk), .rst_n(rst_n),
    .sck_s(synced[2]), .cs_n_s(synced[1]), .sdi_s(synced[0]),
    .rd_load(rd_load), .rd_value(rd_value),
    .word_stb(word_stb), .word_out(word_v),
    .sdo(spi_sdo), .sdo_en(spi_sdo_en)
  );

  spi9_regbank #(.DEV_ID(DEV_ID)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .word_stb(word_stb), .word_in(word_v),
    .core_addr(core_addr), .core_rdata(core_rdata),
    .rd_load(rd_load), .rd_value(rd_value),
    .push(push), .push_data(push_data)
  );

  spi9_fifo #(.W(BYTE_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n),
    .wr_en(push), .wr_data(push_data),
    .rd_valid(pkt_valid), .rd_ready(pkt_ready), .rd_data(pkt_data)
  );
endmodule

// File: tb/spi9_cfg_slave_test.sv
module spi9_cfg_slave_test;
  localparam int HALF  = 6;
  localparam int DEPTH = 16;
  localparam int ID    = 16'h5A17;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sck = 1'b0, cs_n = 1'b1, sdi = 1'b0, pkt_ready = 1'b0;
  logic [7:0] core_addr = 8'h00;
  logic sdo, sdo_en, pkt_valid;
  logic [15:0] core_rdata;
  logic [7:0] pkt_data;

  spi9_cfg_slave uut (
    .clk(clk), .rst_n(rst_n), .spi_sck(sck), .spi_cs_n(cs_n), .spi_sdi(sdi),
    .spi_sdo(sdo), .spi_sdo_en(sdo_en), .core_addr(core_addr), .core_rdata(core_rdata),
    .pkt_valid(pkt_valid), .pkt_ready(pkt_ready), .pkt_data(pkt_data)
  );

  always #4 clk = ~clk;

  int n_cmp = 0, n_bad = 0, cyc = 0, n_popped = 0;
  bit busy = 1'b1, drain = 1'b0, done = 1'b0;

  int mreg [256];
  bit m_cmd, m_armed, m_rdw, m_pay;
  int m_addr, m_idx, m_low, m_pcnt;
  logic [7:0] mq [$];

  task automatic check(input string req, input int act, input int exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  function automatic int mval(input int a);
    if (a == 'hB0) return ID;
    if (a < 'hB0) return 0;
    return mreg[a];
  endfunction

  task automatic model_word(input bit f, input int b);
    if (m_rdw) m_rdw = 0;
    else if (!f) begin
      if (m_armed) begin m_armed = 0; m_rdw = 1; m_cmd = 0; m_pay = 0; end
      else if (b == 'hBF) begin m_pay = 1; m_pcnt = 0; m_cmd = 0; end
      else begin m_cmd = 1; m_addr = b; m_idx = 0; m_pay = 0; end
    end else if (m_pay) begin
      if (m_pcnt < mreg['hBC]) begin
        m_pcnt++;
        if (mq.size() < DEPTH) mq.push_back(8'(b));
      end
    end else if (m_cmd) begin
      if (m_idx == 0) m_low = b;
      else if (m_idx == 1 && m_addr > 'hB0) begin
        int v;
        v = (b << 8) | m_low;
        if (m_addr == 'hC0 && v == 'h0100) begin
          for (int i = 0; i < 256; i++) mreg[i] = 0;
        end else mreg[m_addr] = v;
        if (m_addr == 'hD4 && v == 'h00FA) m_armed = 1;
      end
      if (m_idx < 2) m_idx++;
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bits9(input bit f, input int b);
    for (int i = 8; i >= 0; i--) begin
      sdi = (i == 8) ? f : b[i];
      wait_clk(HALF);
      sck = 1'b1;
      wait_clk(HALF);
      sck = 1'b0;
    end
  endtask

  task automatic send_word(input bit f, input int b);
    busy = 1'b1;
    cs_n = 1'b0;
    wait_clk(HALF);
    bits9(f, b);
    wait_clk(HALF);
    cs_n = 1'b1;
    wait_clk(2 * HALF);
    model_word(f, b);
    busy = 1'b0;
  endtask

  task automatic partial(input int n);
    busy = 1'b1;
    cs_n = 1'b0;
    wait_clk(HALF);
    for (int i = 0; i < n; i++) begin
      sdi = 1'b1;
      wait_clk(HALF);
      sck = 1'b1;
      wait_clk(HALF);
      sck = 1'b0;
    end
    wait_clk(HALF);
    cs_n = 1'b1;
    wait_clk(2 * HALF);
    busy = 1'b0;
  endtask

  task automatic wreg(input int a, input int v);
    send_word(1'b0, a);
    send_word(1'b1, v & 'hFF);
    send_word(1'b1, (v >> 8) & 'hFF);
  endtask

  task automatic chk_read(input string req, input int a);
    int v, en_all;
    wreg('hD4, 'h00FA);
    send_word(1'b0, a);
    busy = 1'b1;
    cs_n = 1'b0;
    wait_clk(HALF);
    check({req, " enable low before read bits"}, sdo_en, 0);
    bits9(1'b0, 'hFA);
    v = 0;
    en_all = 1;
    for (int k = 0; k < 16; k++) begin
      wait_clk(HALF);
      if (!sdo_en) en_all = 0;
      v = (v << 1) | sdo;
      sck = 1'b1;
      wait_clk(HALF);
      sck = 1'b0;
    end
    wait_clk(HALF);
    check({req, " enable high over 16 bits"}, en_all, 1);
    check({req, " enable low after read"}, sdo_en, 0);
    cs_n = 1'b1;
    wait_clk(2 * HALF);
    model_word(1'b0, 'hFA);
    check({req, " serial read value"}, v, mval(a));
    busy = 1'b0;
  endtask

  task automatic chk_core(input string req, input int a);
    @(negedge clk);
    core_addr = 8'(a);
    @(negedge clk);
    check({req, " core port value"}, core_rdata, mval(a));
  endtask

  task automatic drain_all(input string req);
    drain = 1'b1;
    for (int t = 0; t < 400 && mq.size() > 0; t++) @(negedge clk);
    wait_clk(2);
    drain = 1'b0;
    check({req, " model queue emptied"}, mq.size(), 0);
    check({req, " valid low when drained"}, pkt_valid, 0);
  endtask

  // R7 / R5: per-clock comparison of the stream and the data enable against the model
  always @(negedge clk) begin
    if (rst_n && !busy) begin
      check("R7 valid matches model", pkt_valid, mq.size() > 0);
      if (pkt_valid && mq.size() > 0) check("R7 data order", pkt_data, mq[0]);
      check("R5 enable idle", sdo_en, 0);
      pkt_ready = drain && (cyc % 3 != 1);
      if (pkt_ready && pkt_valid && mq.size() > 0) begin
        void'(mq.pop_front());
        n_popped++;
      end
    end else pkt_ready = 1'b0;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      n_bad++;
      $display("FAIL watchdog expired (all requirements) actual=%0d expected<150000", cyc);
      summary();
      $finish;
    end
  end

  initial begin
    int base;
    for (int i = 0; i < 256; i++) mreg[i] = 0;
    m_cmd = 0; m_armed = 0; m_rdw = 0; m_pay = 0;
    m_addr = 0; m_idx = 0; m_low = 0; m_pcnt = 0;
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(3);
    busy = 1'b0;

    // R11 reset state
    check("R11 valid low after reset", pkt_valid, 0);
    check("R11 enable low after reset", sdo_en, 0);
    chk_core("R11", 'hB1);
    chk_core("R11", 'hBC);

    // R3 data without any command
    send_word(1'b1, 'h77);
    send_word(1'b1, 'h66);
    chk_core("R3 stray data", 'hB1);
    chk_core("R3 stray data", 'hC0);

    // R2 / R1 ordinary writes, several patterns
    wreg('hB1, 'h1234);
    chk_core("R2", 'hB1);
    wreg('hB5, 'hA55A);
    chk_core("R2", 'hB5);
    wreg('hC8, 'hFFFF);
    chk_core("R1", 'hC8);
    wreg('hD9, 'hFFFE);
    chk_core("R1", 'hD9);

    // R2 low byte alone does not commit
    send_word(1'b0, 'hB2);
    send_word(1'b1, 'h99);
    send_word(1'b0, 'hB3);
    chk_core("R2 low byte only", 'hB2);

    // R3 third data byte ignored
    send_word(1'b0, 'hB2);
    send_word(1'b1, 'h21);
    send_word(1'b1, 'h43);
    send_word(1'b1, 'hEE);
    send_word(1'b1, 'hDD);
    chk_core("R3 extra bytes", 'hB2);

    // R4 identity and unmapped addresses
    wreg('hB0, 'h1111);
    chk_core("R4 identity", 'hB0);
    wreg('h50, 'h2222);
    chk_core("R4 unmapped", 'h50);

    // R5 read handshake, several values
    chk_read("R5", 'hB1);
    chk_read("R5", 'hB5);
    chk_read("R5", 'hC8);
    chk_read("R5", 'hD9);
    chk_read("R4 identity read", 'hB0);
    chk_read("R4 unmapped read", 'h40);

    // R10 partial words discarded, state kept across select
    send_word(1'b0, 'hB3);
    partial(5);
    send_word(1'b1, 'h34);
    partial(3);
    send_word(1'b1, 'h12);
    chk_core("R10 partial word", 'hB3);

    // R6 payload limited by count, restart on new port command
    wreg('hBC, 5);
    send_word(1'b0, 'hBF);
    for (int i = 0; i < 7; i++) send_word(1'b1, 'h10 + i);
    check("R6 limited burst queued", mq.size(), 5);
    base = n_popped;
    drain_all("R6");
    check("R6 bytes delivered", n_popped - base, 5);
    send_word(1'b0, 'hBF);
    send_word(1'b1, 'hA1);
    send_word(1'b1, 'hA2);
    send_word(1'b0, 'hB7);
    send_word(1'b1, 'hA3);
    check("R6 port closed by command", mq.size(), 2);
    drain_all("R6 restart");

    // R8 overflow beyond FIFO depth
    wreg('hBC, 40);
    send_word(1'b0, 'hBF);
    for (int i = 0; i < 20; i++) send_word(1'b1, 'h40 + i);
    check("R8 model keeps depth", mq.size(), DEPTH);
    base = n_popped;
    drain_all("R8");
    check("R8 bytes after overflow", n_popped - base, DEPTH);

    // R9 soft reset and ordinary value in that register
    wreg('hC0, 'h0055);
    chk_core("R9 ordinary value", 'hC0);
    wreg('hC0, 'h0100);
    chk_core("R9 soft reset", 'hB1);
    chk_core("R9 soft reset", 'hBC);
    chk_read("R9 soft reset read", 'hB5);
    wreg('hB6, 'h0F0F);
    chk_read("R2 after soft reset", 'hB6);

    wait_clk(10);
    done = 1'b1;
    summary();
    $finish;
  end
endmodule